// File: doc/BRIEF.md
# Start-Pulse Contention Bus Acquirer

This block wins ownership of a shared single-wire bus before a frame goes out. A request starts carrier sensing: the line has to stay low for an unbroken idle window. The line is then checked once more. The block enables its driver and holds the line high for a contention pulse. It then floats the line and looks at it. If another device still holds the line high, that device used a longer pulse and wins. This block then backs off and tries again.

A 3-bit back-off counter sets the timing of each attempt. Each loss increments it, and the next attempt uses a longer pulse and a shorter idle window. A host build uses one fixed pulse that is longer than any peripheral pulse, so the host always wins. The counter persists across requests and clears only on reset. After a win the block keeps driving the line low and reports code 0. The caller then sends its frame while holding the request. After the last allowed loss the block reports code 1 with its driver off. Durations are given in microseconds and converted to clock cycles through a cycles-per-microsecond parameter.

Top module: `bus_acquirer`

## Requirements
- R1: After reset, drvEn, drvHigh and done are 0, and the back-off value is 0.
- R2: After a request, the driver is enabled only after lineIn has been sampled low for idleT consecutive cycles, where idleT = (IDLE_MIN_US + (7 - b) * IDLE_STEP_US) * TICK_CYCLES and b is the back-off value. Any high sample restarts the count. Counted from the cycle the request is first seen, drvEn rises idleT + 2 cycles later. Counted from the cycle after a restart, it rises idleT + 1 cycles later.
- R3: In the cycle after the idle window is met, one more sample of lineIn is taken. If it is high, the driver stays disabled and the idle count starts again from zero.
- R4: In peripheral mode (HOST_MODE = 0), drvEn and drvHigh are both 1 for exactly (PULSE_MIN_US + b * PULSE_STEP_US) * TICK_CYCLES cycles.
- R5: In host mode (HOST_MODE = 1), the pulse lasts HOST_PULSE_US * TICK_CYCLES cycles, whatever the value of b.
- R6: After the pulse, drvEn is 0 for SETTLE_CYCLES cycles, and lineIn is sampled in the last of those cycles.
- R7: If that sample is low, the block wins. From the next cycle drvEn = 1, drvHigh = 0, done = 1 and errCode = 0, held until req falls.
- R8: If that sample is high, the back-off value increments modulo 8, done stays 0, and a new idle wait begins using the new value.
- R9: The loss on attempt MAX_TRIES of a request ends it: done = 1, errCode = 1, drvEn = 0, held until req falls.
- R10: While done is 1, lowering req clears done and drvEn on the next cycle. A later request starts with a fresh attempt count.
- R11: The back-off value carries over from one request to the next and is not cleared when a new request starts.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| req | input | 1 | Request for bus ownership; held until the result has been taken |
| lineIn | input | 1 | Sensed bus level, 1 = active |
| drvEn | output | 1 | Line driver enable |
| drvHigh | output | 1 | Level driven when drvEn is 1 (1 = contention pulse, 0 = owned-low) |
| done | output | 1 | Result valid |
| errCode | output | 1 | 0 = bus won, 1 = gave up after MAX_TRIES losses |

## Verification
The bench walks a small configuration through every back-off value, one loss at a time, and measures the idle wait and the pulse width of each attempt to the exact cycle. Wrong scaling, or a counter that fails to wrap after eight losses, would show as a mismatch. It raises the line for a single cycle in the middle of the idle wait, and again in the one-cycle last-check slot. A design that only checks the line when the window ends, or that skips the last check, would enable its driver too early. It lets the eighth attempt lose and checks for a quiet driver and code 1. It issues a request after earlier back-offs to catch a design that clears the counter on each request. A host-mode instance shows that its pulse length does not follow the counter.

// File: rtl/bus_acq_pkg.sv
package bus_acq_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_WAIT,
    ST_ARM,
    ST_PULSE,
    ST_FLOAT,
    ST_WON,
    ST_FAIL
  } acqState_t;

  typedef enum logic [1:0] {
    TGT_IDLE,
    TGT_PULSE,
    TGT_SETTLE
  } tgtSel_t;

  typedef struct packed {
    logic    tmrClr;
    logic    tmrRun;
    logic    boInc;
    logic    attClr;
    logic    attInc;
    tgtSel_t tgtSel;
  } acqStrobe_t;

endpackage

// File: rtl/bus_acq_datapath.sv
module bus_acq_datapath
  import bus_acq_pkg::*;
#(
  parameter int TICK_CYCLES   = 50,
  parameter int IDLE_MIN_US   = 100,
  parameter int IDLE_STEP_US  = 7,
  parameter int PULSE_MIN_US  = 100,
  parameter int PULSE_STEP_US = 14,
  parameter int HOST_PULSE_US = 250,
  parameter int SETTLE_CYCLES = 2,
  parameter int MAX_TRIES     = 8,
  parameter int BO_W          = 3,
  parameter bit HOST_MODE     = 1'b0
) (
  input  logic       clk,
  input  logic       rstN,
  input  acqStrobe_t strb,
  output logic       tmrHit,
  output logic       attLast
);

  localparam int BO_MAX      = (1 << BO_W) - 1;
  localparam int IDLE_TOP    = (IDLE_MIN_US + BO_MAX * IDLE_STEP_US) * TICK_CYCLES;
  localparam int PULSE_TOP   = (PULSE_MIN_US + BO_MAX * PULSE_STEP_US) * TICK_CYCLES;
  localparam int HOST_TOP    = HOST_PULSE_US * TICK_CYCLES;
  localparam int TOP_A       = (IDLE_TOP > PULSE_TOP) ? IDLE_TOP : PULSE_TOP;
  localparam int TOP_B       = (TOP_A > HOST_TOP) ? TOP_A : HOST_TOP;
  localparam int TOP_CYC     = (TOP_B > SETTLE_CYCLES) ? TOP_B : SETTLE_CYCLES;
  localparam int TMR_W       = $clog2(TOP_CYC + 1);
  localparam int ATT_W       = $clog2(MAX_TRIES + 1);

  logic [TMR_W-1:0] timer;
  logic [BO_W-1:0]  backoff;
  logic [ATT_W-1:0] attempts;
  logic [31:0]      idleCyc;
  logic [31:0]      pulseCyc;
  logic [31:0]      tgtCyc;

  always_comb
    idleCyc = 32'((IDLE_MIN_US + (BO_MAX - int'(backoff)) * IDLE_STEP_US) * TICK_CYCLES);

  generate
    if (HOST_MODE) begin : g_hostPulse
      assign pulseCyc = 32'(HOST_TOP);
    end else begin : g_periphPulse
      always_comb
        pulseCyc = 32'((PULSE_MIN_US + int'(backoff) * PULSE_STEP_US) * TICK_CYCLES);
    end
  endgenerate

  always_comb begin
    unique case (strb.tgtSel)
      TGT_PULSE:  tgtCyc = pulseCyc;
      TGT_SETTLE: tgtCyc = 32'(SETTLE_CYCLES);
      default:    tgtCyc = idleCyc;
    endcase
  end

  assign tmrHit  = (32'(timer) == (tgtCyc - 32'd1));
  assign attLast = (32'(attempts) == 32'(MAX_TRIES - 1));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      timer <= '0;
    end else if (strb.tmrClr) begin
      timer <= '0;
    end else if (strb.tmrRun) begin
      timer <= timer + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      backoff <= '0;
    end else if (strb.boInc) begin
      backoff <= backoff + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      attempts <= '0;
    end else if (strb.attClr) begin
      attempts <= '0;
    end else if (strb.attInc) begin
      attempts <= attempts + 1'b1;
    end
  end

  // R8
  bo_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !strb.boInc |=> $stable(backoff));

  // R8
  bo_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.boInc |=> (backoff == $past(backoff) + 1'b1));

  // R9
  att_bound_chk: assert property (@(posedge clk) disable iff (!rstN)
    (32'(attempts) < 32'(MAX_TRIES)));

endmodule

// File: rtl/bus_acq_ctrl.sv
module bus_acq_ctrl
  import bus_acq_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       req,
  input  logic       lineIn,
  input  logic       tmrHit,
  input  logic       attLast,
  output acqStrobe_t strb,
  output logic       drvEn,
  output logic       drvHigh,
  output logic       done,
  output logic       errCode
);

  acqState_t state;
  acqState_t nxt;

  always_comb begin
    nxt         = state;
    strb.tmrClr = 1'b0;
    strb.tmrRun = 1'b0;
    strb.boInc  = 1'b0;
    strb.attClr = 1'b0;
    strb.attInc = 1'b0;
    strb.tgtSel = TGT_IDLE;
    unique case (state)
      ST_IDLE: begin
        if (req) begin
          nxt         = ST_WAIT;
          strb.tmrClr = 1'b1;
          strb.attClr = 1'b1;
        end
      end
      ST_WAIT: begin
        if (lineIn) begin
          strb.tmrClr = 1'b1;
        end else if (tmrHit) begin
          strb.tmrClr = 1'b1;
          nxt         = ST_ARM;
        end else begin
          strb.tmrRun = 1'b1;
        end
      end
      ST_ARM: begin
        strb.tmrClr = 1'b1;
        nxt         = lineIn ? ST_WAIT : ST_PULSE;
      end
      ST_PULSE: begin
        strb.tgtSel = TGT_PULSE;
        if (tmrHit) begin
          strb.tmrClr = 1'b1;
          nxt         = ST_FLOAT;
        end else begin
          strb.tmrRun = 1'b1;
        end
      end
      ST_FLOAT: begin
        strb.tgtSel = TGT_SETTLE;
        if (!tmrHit) begin
          strb.tmrRun = 1'b1;
        end else begin
          strb.tmrClr = 1'b1;
          if (!lineIn) begin
            nxt = ST_WON;
          end else begin
            strb.boInc = 1'b1;
            if (attLast) begin
              nxt = ST_FAIL;
            end else begin
              strb.attInc = 1'b1;
              nxt         = ST_WAIT;
            end
          end
        end
      end
      ST_WON, ST_FAIL: begin
        if (!req) nxt = ST_IDLE;
      end
      default: nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= nxt;
  end

  assign drvEn   = (state == ST_PULSE) || (state == ST_WON);
  assign drvHigh = (state == ST_PULSE);
  assign done    = (state == ST_WON) || (state == ST_FAIL);
  assign errCode = (state == ST_FAIL);

  // R4
  high_needs_en_chk: assert property (@(posedge clk) disable iff (!rstN)
    drvHigh |-> drvEn);

  // R3
  arm_veto_chk: assert property (@(posedge clk) disable iff (!rstN)
    ((state == ST_ARM) && lineIn) |=> !drvEn);

  // R7
  win_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (done && !errCode) |-> (drvEn && !drvHigh));

  // R9
  fail_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    (done && errCode) |-> !drvEn);

  // R10
  done_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    (done && !req) |=> (!done && !drvEn));

endmodule

// File: rtl/bus_acquirer.sv
module bus_acquirer
  import bus_acq_pkg::*;
#(
  parameter int TICK_CYCLES   = 50,
  parameter int IDLE_MIN_US   = 100,
  parameter int IDLE_STEP_US  = 7,
  parameter int PULSE_MIN_US  = 100,
  parameter int PULSE_STEP_US = 14,
  parameter int HOST_PULSE_US = 250,
  parameter int SETTLE_CYCLES = 2,
  parameter int MAX_TRIES     = 8,
  parameter int BO_W          = 3,
  parameter bit HOST_MODE     = 1'b0
) (
  input  logic clk,
  input  logic rstN,
  input  logic req,
  input  logic lineIn,
  output logic drvEn,
  output logic drvHigh,
  output logic done,
  output logic errCode
);

  acqStrobe_t strb;
  logic       tmrHit;
  logic       attLast;

  bus_acq_ctrl ctrl_i (
    .clk     (clk),
    .rstN    (rstN),
    .req     (req),
    .lineIn  (lineIn),
    .tmrHit  (tmrHit),
    .attLast (attLast),
    .strb    (strb),
    .drvEn   (drvEn),
    .drvHigh (drvHigh),
    .done    (done),
    .errCode (errCode)
  );

  bus_acq_datapath #(
    .TICK_CYCLES   (TICK_CYCLES),
    .IDLE_MIN_US   (IDLE_MIN_US),
    .IDLE_STEP_US  (IDLE_STEP_US),
    .PULSE_MIN_US  (PULSE_MIN_US),
    .PULSE_STEP_US (PULSE_STEP_US),
    .HOST_PULSE_US (HOST_PULSE_US),
    .SETTLE_CYCLES (SETTLE_CYCLES),
    .MAX_TRIES     (MAX_TRIES),
    .BO_W          (BO_W),
    .HOST_MODE     (HOST_MODE)
  ) dp_i (
    .clk     (clk),
    .rstN    (rstN),
    .strb    (strb),
    .tmrHit  (tmrHit),
    .attLast (attLast)
  );

endmodule

// File: tb/bus_acquirer_tb_top.sv
`timescale 1ns/1ps
module bus_acquirer_tb_top;

  localparam int TICK   = 2;
  localparam int IMIN   = 3;
  localparam int ISTEP  = 1;
  localparam int PMIN   = 3;
  localparam int PSTEP  = 2;
  localparam int HOSTUS = 20;
  localparam int SETTLE = 2;
  localparam int TRIES  = 8;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic reqA = 1'b0;
  logic reqH = 1'b0;
  logic other = 1'b0;
  logic useHost = 1'b0;
  logic drvEnA, drvHighA, doneA, errA;
  logic drvEnH, drvHighH, doneH, errH;
  logic lineA, lineH;
  logic selEn, selHigh, selDone, selErr;
  int checks = 0;
  int errors = 0;
  int boA = 0;
  int boH = 0;

  always #10 clk = ~clk;

  assign lineA   = other | (drvEnA & drvHighA);
  assign lineH   = other | (drvEnH & drvHighH);
  assign selEn   = useHost ? drvEnH : drvEnA;
  assign selHigh = useHost ? drvHighH : drvHighA;
  assign selDone = useHost ? doneH : doneA;
  assign selErr  = useHost ? errH : errA;

  bus_acquirer #(
    .TICK_CYCLES(TICK), .IDLE_MIN_US(IMIN), .IDLE_STEP_US(ISTEP),
    .PULSE_MIN_US(PMIN), .PULSE_STEP_US(PSTEP), .HOST_PULSE_US(HOSTUS),
    .SETTLE_CYCLES(SETTLE), .MAX_TRIES(TRIES), .BO_W(3), .HOST_MODE(1'b0)
  ) dut_i (
    .clk(clk), .rstN(rstN), .req(reqA), .lineIn(lineA),
    .drvEn(drvEnA), .drvHigh(drvHighA), .done(doneA), .errCode(errA)
  );

  bus_acquirer #(
    .TICK_CYCLES(TICK), .IDLE_MIN_US(IMIN), .IDLE_STEP_US(ISTEP),
    .PULSE_MIN_US(PMIN), .PULSE_STEP_US(PSTEP), .HOST_PULSE_US(HOSTUS),
    .SETTLE_CYCLES(SETTLE), .MAX_TRIES(TRIES), .BO_W(3), .HOST_MODE(1'b1)
  ) dut_host_i (
    .clk(clk), .rstN(rstN), .req(reqH), .lineIn(lineH),
    .drvEn(drvEnH), .drvHigh(drvHighH), .done(doneH), .errCode(errH)
  );

  function automatic int idleT(input int b);
    return (IMIN + (7 - b) * ISTEP) * TICK;
  endfunction

  function automatic int pulseT(input int b);
    return (PMIN + b * PSTEP) * TICK;
  endfunction

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int curBo();
    return useHost ? boH : boA;
  endfunction

  task automatic bumpBo();
    if (useHost) boH = (boH + 1) % 8;
    else         boA = (boA + 1) % 8;
  endtask

  // One arbitration attempt; called at the negedge where the request was
  // raised (fromReq) or where the contender let go of the line.
  task automatic runAttempt(input bit fromReq, input bit lose, input bit lastTry);
    int n;
    int w;
    int expIdle;
    int expPulse;
    bit floatBad;
    expIdle  = idleT(curBo()) + (fromReq ? 2 : 1);
    expPulse = useHost ? HOSTUS * TICK : pulseT(curBo());
    n = 0;
    while (!selEn && n < 5000) begin
      @(negedge clk);
      n++;
    end
    check(n == expIdle, "R2 idle wait", n, expIdle);
    if (lose) other = 1'b1;
    w = 0;
    while (selEn && selHigh && w < 5000) begin
      w++;
      @(negedge clk);
    end
    if (useHost) check(w == expPulse, "R5 host pulse", w, expPulse);
    else         check(w == expPulse, "R4 pulse width", w, expPulse);
    if (lose) begin
      floatBad = (selEn != 1'b0);
      for (int i = 0; i < SETTLE; i++) begin
        @(negedge clk);
        if (!lastTry || i < SETTLE - 1) floatBad |= (selEn != 1'b0);
      end
      check(!floatBad, "R6 float during check", int'(floatBad), 0);
      other = 1'b0;
      bumpBo();
      if (lastTry) begin
        check(selDone && selErr && !selEn, "R9 give up",
              int'({selDone, selErr, selEn}), 3'b110);
      end else begin
        check(!selDone, "R8 retry", int'(selDone), 0);
      end
    end else begin
      n = 1;
      while (!selEn && n < 5000) begin
        @(negedge clk);
        n++;
      end
      check(n == SETTLE + 1, "R6 float length", n, SETTLE + 1);
      check(selDone && !selErr && !selHigh, "R7 win",
            int'({selDone, selErr, selHigh}), 3'b100);
    end
  endtask

  task automatic endRequest();
    if (useHost) reqH = 1'b0;
    else         reqA = 1'b0;
    @(negedge clk);
    check(!selDone && !selEn, "R10 release", int'({selDone, selEn}), 0);
  endtask

  task automatic raiseReq();
    if (useHost) reqH = 1'b1;
    else         reqA = 1'b1;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=expired expected=finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    bit bad;
    repeat (3) @(negedge clk);
    // R1 reset state
    check(!drvEnA && !drvHighA && !doneA, "R1 in reset",
          int'({drvEnA, drvHighA, doneA}), 0);
    rstN = 1'b1;
    repeat (3) @(negedge clk);
    check(!drvEnA && !doneA && !drvEnH && !doneH, "R1 after reset",
          int'({drvEnA, doneA, drvEnH, doneH}), 0);

    // R2 R7 win first attempt with back-off 0
    useHost = 1'b0;
    raiseReq();
    runAttempt(1'b1, 1'b0, 1'b0);
    repeat (5) @(negedge clk);
    check(doneA && drvEnA && !drvHighA, "R7 held", int'({doneA, drvEnA, drvHighA}), 3'b110);
    endRequest();

    // R8 R9 lose every attempt: back-off sweeps 0..7 and wraps
    raiseReq();
    for (int t = 0; t < TRIES; t++) begin
      runAttempt(t == 0, 1'b1, t == TRIES - 1);
    end
    repeat (4) @(negedge clk);
    check(doneA && errA && !drvEnA, "R9 held", int'({doneA, errA, drvEnA}), 3'b110);
    endRequest();

    // R8 three losses, then win with back-off 3
    raiseReq();
    for (int t = 0; t < 3; t++) runAttempt(t == 0, 1'b1, 1'b0);
    runAttempt(1'b0, 1'b0, 1'b0);
    endRequest();

    // R11 back-off kept across requests: new request uses value 3
    raiseReq();
    runAttempt(1'b1, 1'b0, 1'b0);
    endRequest();

    // R2 high sample in mid-wait restarts the count
    raiseReq();
    repeat (5) @(negedge clk);
    other = 1'b1;
    @(negedge clk);
    other = 1'b0;
    check(!drvEnA, "R2 no early enable", int'(drvEnA), 0);
    runAttempt(1'b0, 1'b0, 1'b0);
    endRequest();

    // R3 line active in the last-check slot withholds the enable
    raiseReq();
    bad = 1'b0;
    for (int i = 0; i < idleT(boA) + 1; i++) begin
      @(negedge clk);
      bad |= drvEnA;
    end
    other = 1'b1;
    @(negedge clk);
    bad |= drvEnA;
    other = 1'b0;
    check(!bad, "R3 enable withheld", int'(bad), 0);
    runAttempt(1'b0, 1'b0, 1'b0);
    endRequest();

    // R5 host mode: fixed pulse while its own back-off moves
    useHost = 1'b1;
    raiseReq();
    runAttempt(1'b1, 1'b1, 1'b0);
    runAttempt(1'b0, 1'b1, 1'b0);
    runAttempt(1'b0, 1'b0, 1'b0);
    endRequest();

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule